// File: doc/BRIEF.md
# External Bus Release Handshake Controller

This block lets an outside bus master, such as a DMA engine, take over the processor's external memory bus. The outside master pulls an active-low request line. The controller brings that line into the system clock domain and stops the core from starting any new bus cycle. It then waits for the cycle in progress to finish, including any wait-state stretch. Next it switches off the output drivers of the address, data, strobe and chip-select groups. Only after that does it pull the active-low acknowledge low.

When the request is removed, the order is reversed. The acknowledge rises first, and the drivers come back on one clock later. After that the core may start cycles again.

A request that is withdrawn before the bus has gone quiet is abandoned. In that case the drivers never turn off and no acknowledge is given. While the bus is granted away, the outside master reaches only the external pins. Nothing internal can be reached through them.

Top module: `bus_yield_ctrl`

## Requirements
- R1: During and right after reset, `yield_ack_n` is 1, all four output-enable groups are 1 (driving) and `cycle_stall` is 0.
- R2: The request passes through `SYNC_STAGES` flops. `cycle_stall` rises exactly `SYNC_STAGES`+1 rising edges after `yield_req_n` falls, and not earlier.
- R3: While `bus_busy` is 1 or `wait_n` is 0 (a cycle is in progress or stretched), the drivers stay enabled and `yield_ack_n` stays 1, however long the request has been pending.
- R4: On the first edge at which a pending request sees `bus_busy`=0 and `wait_n`=1, all four enables fall together. `yield_ack_n` falls on the next edge.
- R5: Whenever `yield_ack_n` is 0, all four output enables are 0.
- R6: When `yield_req_n` returns to 1, `yield_ack_n` rises `SYNC_STAGES`+1 edges later. The enables return to 1, and `cycle_stall` to 0, on the edge after that.
- R7: `cycle_stall` is 1 from the controller's reaction to a request until the bus is driven again. In particular, it is 1 whenever any enable is 0.
- R8: If the request is withdrawn while the controller is still waiting for the bus to go quiet, the controller returns to owning the bus. The enables never drop and `yield_ack_n` never falls.
- R9: While the bus is granted away, changes on `bus_busy` and `wait_n` have no effect: `yield_ack_n` stays 0 and the enables stay 0.
- R10: The four enable outputs always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| yield_req_n | input | 1 | Bus request from outside master, active low, asynchronous |
| wait_n | input | 1 | Wait-state input, 0 stretches the current cycle |
| bus_busy | input | 1 | Core indicates a bus cycle is in progress |
| cycle_stall | output | 1 | Holds off the core's next bus-cycle start |
| yield_ack_n | output | 1 | Acknowledge to outside master, active low |
| addr_oe | output | 1 | Enable for address and multiplexed address/data drivers |
| data_oe | output | 1 | Enable for data drivers |
| strobe_oe | output | 1 | Enable for read, write, high-write, read/write and row-strobe drivers |
| cs_oe | output | 1 | Enable for chip-select / column-strobe drivers |

## Verification
The bench builds the controller with `SYNC_STAGES`=3 rather than the default 2. This shows that every latency the requirements state scales with the parameter, and is not fixed at two flops. At this depth each grant and release takes enough cycles that a request can be withdrawn while the controller is still draining. That makes the abandoned-request path and the drain held by a stretched cycle reachable with exact edge counts.

// File: rtl/bus_yield_pkg.sv
// Shared types for the bus release handshake controller.
// Assumes: nothing beyond IEEE 1800-2017.
package bus_yield_pkg;

    // Handshake sequencer states
    typedef enum logic [1:0] {
        ST_OWN      = 2'd0,   // core owns and drives the bus
        ST_DRAIN    = 2'd1,   // request seen, waiting for bus quiet
        ST_RELEASED = 2'd2,   // drivers off, grant given or about to be
        ST_RECLAIM  = 2'd3    // grant withdrawn, drivers about to return
    } yield_state_t;

endpackage

// File: rtl/byc_req_sync.sv
// Request synchronizer: brings the asynchronous active-low request into the
// clock domain through STAGES flops, resetting to the inactive level (1).
// Assumes: STAGES >= 2.
module byc_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw request through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_n};
    end

    assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/byc_seq_fsm.sv
// Handshake sequencer: decides when to release and reclaim the bus.
// Issues one-cycle pulses to turn the driver bank off or on, and owns
// the registered acknowledge. Drivers go off one edge before the
// acknowledge falls; the acknowledge rises one edge before the drivers
// return.
// Assumes: req_on is already synchronous; bus_quiet is combinational from core.
module byc_seq_fsm
    import bus_yield_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_on,
    input  logic bus_quiet,
    output logic drive_off,
    output logic drive_on,
    output logic ack_n,
    output logic stall
);
    yield_state_t state_q, state_d;
    logic         ack_n_q, ack_n_d;

    // Next-state and acknowledge decisions
    always_comb begin
        state_d   = state_q;
        ack_n_d   = ack_n_q;
        drive_off = 1'b0;
        drive_on  = 1'b0;
        unique case (state_q)
            ST_OWN: begin
                if (req_on) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!req_on) begin
                    state_d = ST_OWN;
                end else if (bus_quiet) begin
                    state_d   = ST_RELEASED;
                    drive_off = 1'b1;
                end
            end
            ST_RELEASED: begin
                if (!req_on) begin
                    state_d = ST_RECLAIM;
                    ack_n_d = 1'b1;
                end else begin
                    ack_n_d = 1'b0;
                end
            end
            ST_RECLAIM: begin
                state_d  = ST_OWN;
                drive_on = 1'b1;
            end
            default: state_d = ST_OWN;
        endcase
    end

    // State and acknowledge registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OWN;
            ack_n_q <= 1'b1;
        end else begin
            state_q <= state_d;
            ack_n_q <= ack_n_d;
        end
    end

    assign ack_n = ack_n_q;
    assign stall = (state_q != ST_OWN);
endmodule

// File: rtl/byc_oe_bank.sv
// Driver-enable bank: one enable flop per output group, all cleared or set
// by the sequencer's pulses. Reset value is 1 (core drives the bus).
// Assumes: off and on pulses are never high in the same cycle.
module byc_oe_bank #(
    parameter int GROUPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              off_pulse,
    input  logic              on_pulse,
    output logic [GROUPS-1:0] oe
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        // Hold the enable of one output group
        always_ff @(posedge clk) begin
            if (!rst_n)         oe[g] <= 1'b1;
            else if (off_pulse) oe[g] <= 1'b0;
            else if (on_pulse)  oe[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/bus_yield_ctrl.sv
// Top level of the external bus release handshake controller.
// Synchronizes the request, drains any active or wait-stretched cycle,
// disables every external bus driver group, then acknowledges. On release
// it drops the acknowledge before the drivers return.
// Assumes: enables are active high; request/acknowledge are active low.
module bus_yield_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic yield_req_n,
    input  logic wait_n,
    input  logic bus_busy,
    output logic cycle_stall,
    output logic yield_ack_n,
    output logic addr_oe,
    output logic data_oe,
    output logic strobe_oe,
    output logic cs_oe
);
    localparam int N_GROUPS = 4;

    logic                req_sync_n;
    logic                off_p, on_p;
    logic [N_GROUPS-1:0] oe_vec;

    byc_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (yield_req_n),
        .sync_n  (req_sync_n)
    );

    byc_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_on    (!req_sync_n),
        .bus_quiet (!bus_busy && wait_n),
        .drive_off (off_p),
        .drive_on  (on_p),
        .ack_n     (yield_ack_n),
        .stall     (cycle_stall)
    );

    byc_oe_bank #(.GROUPS(N_GROUPS)) u_oe (
        .clk       (clk),
        .rst_n     (rst_n),
        .off_pulse (off_p),
        .on_pulse  (on_p),
        .oe        (oe_vec)
    );

    assign addr_oe   = oe_vec[0];
    assign data_oe   = oe_vec[1];
    assign strobe_oe = oe_vec[2];
    assign cs_oe     = oe_vec[3];
endmodule

// File: rtl/bus_yield_ctrl_chk.sv
// Port-level checker for bus_yield_ctrl, attached by bind.
// Assumes: reset is held for at least one clock edge.
module bus_yield_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic wait_n,
    input logic bus_busy,
    input logic cycle_stall,
    input logic yield_ack_n,
    input logic addr_oe,
    input logic data_oe,
    input logic strobe_oe,
    input logic cs_oe
);
    logic [3:0] oe_all;
    assign oe_all = {cs_oe, strobe_oe, data_oe, addr_oe};

    assert_off_while_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !yield_ack_n |-> (oe_all == 4'b0000));

    assert_ack_falls_after_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(yield_ack_n) |-> ($past(oe_all) == 4'b0000));

    assert_drive_after_ack_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_oe) |-> $past(yield_ack_n));

    assert_stall_when_undriven_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_all != 4'b1111) |-> cycle_stall);

    assert_groups_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_all == 4'b0000) || (oe_all == 4'b1111));

    assert_hold_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_busy || !wait_n) && (oe_all == 4'b1111)) |=> (oe_all == 4'b1111));
endmodule

bind bus_yield_ctrl bus_yield_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wait_n      (wait_n),
    .bus_busy    (bus_busy),
    .cycle_stall (cycle_stall),
    .yield_ack_n (yield_ack_n),
    .addr_oe     (addr_oe),
    .data_oe     (data_oe),
    .strobe_oe   (strobe_oe),
    .cs_oe       (cs_oe)
);

// File: tb/tb_bus_yield_ctrl.sv
// Directed bench for bus_yield_ctrl: one task per scenario.
// Inputs are driven and outputs sampled on the falling clock edge.
module tb_bus_yield_ctrl;
    localparam int SYNC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic yield_req_n = 1'b1;
    logic wait_n = 1'b1;
    logic bus_busy = 1'b0;
    logic cycle_stall, yield_ack_n, addr_oe, data_oe, strobe_oe, cs_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bus_yield_ctrl #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .yield_req_n(yield_req_n), .wait_n(wait_n),
        .bus_busy(bus_busy), .cycle_stall(cycle_stall), .yield_ack_n(yield_ack_n),
        .addr_oe(addr_oe), .data_oe(data_oe), .strobe_oe(strobe_oe), .cs_oe(cs_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int oe4();
        return {cs_oe, strobe_oe, data_oe, addr_oe};
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(3);
        chk("R1 ack in reset", yield_ack_n, 1);
        chk("R1 oe in reset", oe4(), 15);
        chk("R1 stall in reset", cycle_stall, 0);
        rst_n = 1'b1;
        tick(2);
        chk("R1 ack after reset", yield_ack_n, 1);
        chk("R1 oe after reset", oe4(), 15);
    endtask

    // grant from an idle bus; exact edge counts
    task automatic t_idle_grant();
        yield_req_n = 1'b0;
        tick(SYNC);
        chk("R2 no stall before sync", cycle_stall, 0);
        tick(1);
        chk("R2 stall after sync", cycle_stall, 1);
        chk("R2 oe still on", oe4(), 15);
        tick(1);
        chk("R4 oe off together", oe4(), 0);
        chk("R4 ack not yet low", yield_ack_n, 1);
        tick(1);
        chk("R4 ack low next edge", yield_ack_n, 0);
        chk("R7 stall while granted", cycle_stall, 1);
    endtask

    // inputs ignored while granted, then release
    task automatic t_release();
        bus_busy = 1'b1; wait_n = 1'b0;
        tick(3);
        chk("R9 ack stays low", yield_ack_n, 0);
        chk("R9 oe stays off", oe4(), 0);
        bus_busy = 1'b0; wait_n = 1'b1;
        tick(1);
        chk("R5 oe off while ack low", oe4(), 0);
        yield_req_n = 1'b1;
        tick(SYNC);
        chk("R6 ack still low", yield_ack_n, 0);
        tick(1);
        chk("R6 ack high", yield_ack_n, 1);
        chk("R6 oe still off", oe4(), 0);
        chk("R7 stall during reclaim", cycle_stall, 1);
        tick(1);
        chk("R6 oe back on", oe4(), 15);
        chk("R6 stall released", cycle_stall, 0);
    endtask

    // drain held by active cycle and wait stretch
    task automatic t_wait_drain();
        bus_busy = 1'b1; wait_n = 1'b0;
        yield_req_n = 1'b0;
        tick(SYNC + 6);
        chk("R3 oe on while waiting", oe4(), 15);
        chk("R3 ack high while waiting", yield_ack_n, 1);
        chk("R7 stall while draining", cycle_stall, 1);
        wait_n = 1'b1;
        tick(3);
        chk("R3 oe on while busy", oe4(), 15);
        chk("R3 ack high while busy", yield_ack_n, 1);
        bus_busy = 1'b0;
        tick(1);
        chk("R4 oe off after quiet", oe4(), 0);
        chk("R4 ack high one edge", yield_ack_n, 1);
        tick(1);
        chk("R4 ack low after drain", yield_ack_n, 0);
    endtask

    // request withdrawn while draining
    task automatic t_abort();
        int bad = 0;
        bus_busy = 1'b1;
        yield_req_n = 1'b0;
        tick(SYNC + 3);
        chk("R8 stall while draining", cycle_stall, 1);
        yield_req_n = 1'b1;
        for (int i = 0; i < SYNC; i++) begin
            tick(1);
            if (yield_ack_n != 1'b1 || oe4() != 15) bad++;
        end
        tick(1);
        chk("R8 stall dropped", cycle_stall, 0);
        bus_busy = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            if (yield_ack_n != 1'b1 || oe4() != 15) bad++;
        end
        chk("R8 no grant after abort", bad, 0);
        chk("R8 oe on after abort", oe4(), 15);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_idle_grant();
        t_release();
        tick(2);
        t_wait_drain();
        t_release();
        tick(2);
        t_abort();
        t_idle_grant();
        t_release();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule